// File: doc/BRIEF.md
# Segmented Window Access Translator

This block sits between a requester that issues 8-, 16- and 32-bit reads and writes addressed by a core index and a 16-bit offset, and a 16-bit data window that has two segments. The window reaches one core at a time. Which core it reaches is changed by a separate switch sequencer. Which segment it shows is changed through one configuration register. The block keeps a cached copy of the mapped core and of the selected segment. It asks for a core change or a segment change only when the next request needs one, and then performs the data access as one or two 16-bit window beats.

The requester side is a valid/ready pair for requests and another for responses. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response has been taken with `rsp_valid` and `rsp_ready` high. The response is held unchanged for as long as `rsp_ready` is low. On the switch, configuration and window ports the block holds its request high. A transfer completes in the cycle the matching acknowledge is high, and read data is sampled in that same cycle.

A segment change writes the segment number to configuration address 0x34 and then reads it back. If the value read back differs, the block pauses and tries again, up to a fixed number of rounds. When a core change or segment change fails, the block returns an error flag and all-ones read data, and it performs no window access.

Top module: `seg_window_xlat`

## Requirements
- R1: An offset of 0x800 or above selects segment 1, and the window address is the offset minus 0x800. An offset below 0x800 selects segment 0, and the window address equals the offset.
- R2: `csw_req` is raised only when no core is validly mapped or the requested core differs from the mapped one. It stays high with `csw_core` steady until `csw_done`, and `csw_ok` in that cycle tells whether the change succeeded.
- R3: A segment change is started only when the cached segment is invalid or differs from the one needed. Each round writes the segment number (bits above bit 0 zero) to configuration address 0x34 and then reads that address back.
- R4: When the value read back does not match, the block waits RETRY_WAIT cycles and starts a new round. It makes at most MAX_TRIES rounds (default 3), and a match in the last round still counts as success.
- R5: A 32-bit access is two 16-bit window beats: the low half at the window address first, then the high half at the window address plus 2. Read data is low | (high << 16).
- R6: An 8-bit access uses byte lane offset[0] (0 gives `win_be`=01 and the low byte, 1 gives `win_be`=10 and the high byte). The write byte is driven on both lanes, and the read byte is zero-extended. A 16-bit access uses `win_be`=11. `req_size` is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit.
- R7: When a core change or segment change fails, the response has `rsp_err`=1 and `rsp_rdata` set to all ones at the request width (0xFF, 0xFFFF or 0xFFFFFFFF, zero-extended), no window beat is issued, and the failed cache entry becomes invalid.
- R8: After reset, `req_ready` stays low until a verified change to segment 0 has finished.
- R9: `req_ready` is low from acceptance until the response handshake. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` and `rsp_err` hold.
- R10: The core change finishes before the segment change, and the segment change finishes before any window beat. At most one of `csw_req`, `cfg_req` and `win_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_size | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit |
| req_write | input | 1 | 1 for write |
| req_core | input | CORE_W | Target core index |
| req_offset | input | OFF_W | Byte offset within the core |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_rdata | output | 32 | Read data, zero-extended |
| rsp_err | output | 1 | Core or segment change failed |
| csw_req | output | 1 | Core change request |
| csw_core | output | CORE_W | Core to map |
| csw_done | input | 1 | Core change finished |
| csw_ok | input | 1 | Core change succeeded, valid with csw_done |
| cfg_req | output | 1 | Configuration access request |
| cfg_we | output | 1 | 1 for write, 0 for read-back |
| cfg_addr | output | CFG_AW | Configuration address (0x34) |
| cfg_wdata | output | CFG_DW | Segment number written |
| cfg_ack | input | 1 | Configuration access complete |
| cfg_rdata | input | CFG_DW | Read-back value, valid with cfg_ack |
| win_req | output | 1 | Window beat request |
| win_we | output | 1 | Window beat is a write |
| win_addr | output | OFF_W | Window byte address within the segment |
| win_be | output | 2 | Byte lane enables |
| win_wdata | output | 16 | Window write data |
| win_ack | input | 1 | Window beat complete |
| win_rdata | input | 16 | Window read data, valid with win_ack |

## Verification
The case that matters most is a single request that needs both a core change and a segment change. It then passes through the switch sequencer, the segment register and the window in turn. The bench provokes this by moving to a new core and across the 0x800 boundary in the same request. It then counts the core changes and configuration writes it saw and checks that the data read comes from the segment the request asked for. A failed segment change is provoked in a write request. The bench confirms through a later read that the dropped write left the window unchanged, and it checks that the next request performs a fresh segment change even though the hardware already holds the needed value.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2
  } xfer_size_e;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_INIT_WAIT,
    ST_IDLE,
    ST_CORE,
    ST_SEG_GO,
    ST_SEG_WAIT,
    ST_BEAT_LO,
    ST_BEAT_HI,
    ST_RESP
  } xlat_state_e;
endpackage

// File: rtl/seg_xlat_decode.sv
module seg_xlat_decode #(
  parameter int          OFF_W = 16,
  parameter logic [15:0] SPLIT = 16'h0800
) (
  input  logic [OFF_W-1:0] offset,
  output logic             seg_sel,
  output logic [OFF_W-1:0] local_off
);
  localparam logic [OFF_W-1:0] SPLIT_W = OFF_W'(SPLIT);

  always_comb begin
    seg_sel   = (offset >= SPLIT_W);
    local_off = seg_sel ? (offset - SPLIT_W) : offset;
  end
endmodule

// File: rtl/seg_xlat_segsw.sv
module seg_xlat_segsw #(
  parameter int              MAX_TRIES  = 3,
  parameter int              RETRY_WAIT = 10,
  parameter int              CFG_AW     = 8,
  parameter int              CFG_DW     = 8,
  parameter logic [CFG_AW-1:0] REG_ADDR = 8'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              target,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [CFG_DW-1:0] cfg_wdata,
  input  logic              cfg_ack,
  input  logic [CFG_DW-1:0] cfg_rdata,
  output logic              done,
  output logic              ok
);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam int WAIT_W = $clog2(RETRY_WAIT + 1);
  localparam logic [TRY_W-1:0]  LAST_TRY  = TRY_W'(MAX_TRIES - 1);
  localparam logic [WAIT_W-1:0] LAST_WAIT = WAIT_W'(RETRY_WAIT - 1);

  typedef enum logic [1:0] {SS_IDLE, SS_WR, SS_RD, SS_PAUSE} sw_state_e;

  sw_state_e         st;
  logic              tgt;
  logic [TRY_W-1:0]  tries;
  logic [WAIT_W-1:0] wcnt;

  assign cfg_req   = (st == SS_WR) || (st == SS_RD);
  assign cfg_we    = (st == SS_WR);
  assign cfg_addr  = REG_ADDR;
  assign cfg_wdata = CFG_DW'(tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SS_IDLE;
      tgt   <= 1'b0;
      tries <= '0;
      wcnt  <= '0;
      done  <= 1'b0;
      ok    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SS_IDLE: begin
          if (start) begin
            tgt   <= target;
            tries <= '0;
            st    <= SS_WR;
          end
        end
        SS_WR: begin
          if (cfg_ack) st <= SS_RD;
        end
        SS_RD: begin
          if (cfg_ack) begin
            if (cfg_rdata == CFG_DW'(tgt)) begin
              done <= 1'b1;
              ok   <= 1'b1;
              st   <= SS_IDLE;
            end else if (tries == LAST_TRY) begin
              done <= 1'b1;
              ok   <= 1'b0;
              st   <= SS_IDLE;
            end else begin
              tries <= tries + 1'b1;
              wcnt  <= '0;
              st    <= SS_PAUSE;
            end
          end
        end
        SS_PAUSE: begin
          if (wcnt == LAST_WAIT) st <= SS_WR;
          else                   wcnt <= wcnt + 1'b1;
        end
        default: st <= SS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_xlat_lanes.sv
module seg_xlat_lanes
  import seg_xlat_pkg::*;
(
  input  logic [1:0]  size,
  input  logic        odd,
  input  logic        beat_hi,
  input  logic [31:0] wdata,
  input  logic [15:0] win_rdata,
  input  logic [15:0] lo_hold,
  output logic [15:0] win_wdata,
  output logic [1:0]  win_be,
  output logic [31:0] rd_word,
  output logic [31:0] ones_word
);
  always_comb begin
    case (size)
      SZ_8: begin
        win_wdata = {wdata[7:0], wdata[7:0]};
        win_be    = odd ? 2'b10 : 2'b01;
        rd_word   = {24'h0, odd ? win_rdata[15:8] : win_rdata[7:0]};
        ones_word = 32'h0000_00FF;
      end
      SZ_16: begin
        win_wdata = wdata[15:0];
        win_be    = 2'b11;
        rd_word   = {16'h0, win_rdata};
        ones_word = 32'h0000_FFFF;
      end
      default: begin
        win_wdata = beat_hi ? wdata[31:16] : wdata[15:0];
        win_be    = 2'b11;
        rd_word   = {win_rdata, lo_hold};
        ones_word = 32'hFFFF_FFFF;
      end
    endcase
  end
endmodule

// File: rtl/seg_window_xlat.sv
module seg_window_xlat
  import seg_xlat_pkg::*;
#(
  parameter int              CORE_W     = 4,
  parameter int              OFF_W      = 16,
  parameter logic [15:0]     SEG_SPLIT  = 16'h0800,
  parameter int              MAX_TRIES  = 3,
  parameter int              RETRY_WAIT = 10,
  parameter int              CFG_AW     = 8,
  parameter int              CFG_DW     = 8,
  parameter logic [CFG_AW-1:0] SEG_REG  = 8'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [CORE_W-1:0] req_core,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              csw_req,
  output logic [CORE_W-1:0] csw_core,
  input  logic              csw_done,
  input  logic              csw_ok,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [CFG_DW-1:0] cfg_wdata,
  input  logic              cfg_ack,
  input  logic [CFG_DW-1:0] cfg_rdata,
  output logic              win_req,
  output logic              win_we,
  output logic [OFF_W-1:0]  win_addr,
  output logic [1:0]        win_be,
  output logic [15:0]       win_wdata,
  input  logic              win_ack,
  input  logic [15:0]       win_rdata
);
  localparam logic [OFF_W-1:0] HI_STEP = OFF_W'(2);

  xlat_state_e       st;
  logic [1:0]        r_size;
  logic              r_write;
  logic [CORE_W-1:0] r_core;
  logic              r_seg;
  logic [OFF_W-1:0]  r_loc;
  logic [31:0]       r_wdata;
  logic [15:0]       lo_hold;
  logic [CORE_W-1:0] core_q;
  logic              core_vld;
  logic              seg_q;
  logic              seg_vld;
  logic [31:0]       rsp_data_q;
  logic              rsp_err_q;

  logic              dec_seg;
  logic [OFF_W-1:0]  dec_loc;
  logic              sw_start;
  logic              sw_target;
  logic              sw_done;
  logic              sw_ok;
  logic              beat_hi;
  logic [31:0]       rd_word;
  logic [31:0]       ones_word;
  logic              seg_miss;

  seg_xlat_decode #(.OFF_W(OFF_W), .SPLIT(SEG_SPLIT)) u_decode (
    .offset    (req_offset),
    .seg_sel   (dec_seg),
    .local_off (dec_loc)
  );

  seg_xlat_segsw #(
    .MAX_TRIES (MAX_TRIES),
    .RETRY_WAIT(RETRY_WAIT),
    .CFG_AW    (CFG_AW),
    .CFG_DW    (CFG_DW),
    .REG_ADDR  (SEG_REG)
  ) u_segsw (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sw_start),
    .target    (sw_target),
    .cfg_req   (cfg_req),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_ack   (cfg_ack),
    .cfg_rdata (cfg_rdata),
    .done      (sw_done),
    .ok        (sw_ok)
  );

  seg_xlat_lanes u_lanes (
    .size      (r_size),
    .odd       (r_loc[0]),
    .beat_hi   (beat_hi),
    .wdata     (r_wdata),
    .win_rdata (win_rdata),
    .lo_hold   (lo_hold),
    .win_wdata (win_wdata),
    .win_be    (win_be),
    .rd_word   (rd_word),
    .ones_word (ones_word)
  );

  assign beat_hi   = (st == ST_BEAT_HI);
  assign seg_miss  = !seg_vld || (seg_q != r_seg);
  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_rdata = rsp_data_q;
  assign rsp_err   = rsp_err_q;
  assign csw_req   = (st == ST_CORE);
  assign csw_core  = r_core;
  assign sw_start  = (st == ST_INIT) || (st == ST_SEG_GO);
  assign sw_target = (st == ST_INIT) ? 1'b0 : r_seg;
  assign win_req   = (st == ST_BEAT_LO) || (st == ST_BEAT_HI);
  assign win_we    = r_write;
  assign win_addr  = beat_hi ? (r_loc + HI_STEP) : r_loc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_INIT;
      r_size     <= 2'd0;
      r_write    <= 1'b0;
      r_core     <= '0;
      r_seg      <= 1'b0;
      r_loc      <= '0;
      r_wdata    <= '0;
      lo_hold    <= '0;
      core_q     <= '0;
      core_vld   <= 1'b0;
      seg_q      <= 1'b0;
      seg_vld    <= 1'b0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      case (st)
        ST_INIT: st <= ST_INIT_WAIT;
        ST_INIT_WAIT: begin
          if (sw_done) begin
            seg_q   <= 1'b0;
            seg_vld <= sw_ok;
            st      <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (req_valid) begin
            r_size  <= req_size;
            r_write <= req_write;
            r_core  <= req_core;
            r_seg   <= dec_seg;
            r_loc   <= dec_loc;
            r_wdata <= req_wdata;
            if (!core_vld || (core_q != req_core))
              st <= ST_CORE;
            else if (!seg_vld || (seg_q != dec_seg))
              st <= ST_SEG_GO;
            else
              st <= ST_BEAT_LO;
          end
        end
        ST_CORE: begin
          if (csw_done) begin
            if (csw_ok) begin
              core_q   <= r_core;
              core_vld <= 1'b1;
              st       <= seg_miss ? ST_SEG_GO : ST_BEAT_LO;
            end else begin
              core_vld   <= 1'b0;
              rsp_data_q <= ones_word;
              rsp_err_q  <= 1'b1;
              st         <= ST_RESP;
            end
          end
        end
        ST_SEG_GO: st <= ST_SEG_WAIT;
        ST_SEG_WAIT: begin
          if (sw_done) begin
            if (sw_ok) begin
              seg_q   <= r_seg;
              seg_vld <= 1'b1;
              st      <= ST_BEAT_LO;
            end else begin
              seg_vld    <= 1'b0;
              rsp_data_q <= ones_word;
              rsp_err_q  <= 1'b1;
              st         <= ST_RESP;
            end
          end
        end
        ST_BEAT_LO: begin
          if (win_ack) begin
            if (r_size == SZ_8 || r_size == SZ_16) begin
              rsp_data_q <= r_write ? 32'h0 : rd_word;
              rsp_err_q  <= 1'b0;
              st         <= ST_RESP;
            end else begin
              lo_hold <= win_rdata;
              st      <= ST_BEAT_HI;
            end
          end
        end
        ST_BEAT_HI: begin
          if (win_ack) begin
            rsp_data_q <= r_write ? 32'h0 : rd_word;
            rsp_err_q  <= 1'b0;
            st         <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_window_xlat_chk.sv
module seg_window_xlat_chk #(
  parameter int              CORE_W  = 4,
  parameter int              CFG_AW  = 8,
  parameter int              CFG_DW  = 8,
  parameter logic [CFG_AW-1:0] SEG_REG = 8'h34
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              csw_req,
  input logic [CORE_W-1:0] csw_core,
  input logic              csw_done,
  input logic              cfg_req,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_DW-1:0] cfg_wdata,
  input logic              win_req
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  // R9
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({csw_req, cfg_req, win_req}));

  // R2
  core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csw_req && !csw_done |=> csw_req && $stable(csw_core));

  // R3
  seg_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_addr == SEG_REG) && (cfg_wdata[CFG_DW-1:1] == '0));

  // R7
  err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> (rsp_rdata == 32'h0000_00FF) ||
                             (rsp_rdata == 32'h0000_FFFF) ||
                             (rsp_rdata == 32'hFFFF_FFFF));
endmodule

bind seg_window_xlat seg_window_xlat_chk #(
  .CORE_W (CORE_W),
  .CFG_AW (CFG_AW),
  .CFG_DW (CFG_DW),
  .SEG_REG(SEG_REG)
) u_chk (.*);

// File: tb/seg_window_xlat_bench.sv
module seg_window_xlat_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_TRIES  = 3;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_size = 2'd0;
  logic        req_write = 1'b0;
  logic [3:0]  req_core = 4'd0;
  logic [15:0] req_offset = 16'h0;
  logic [31:0] req_wdata = 32'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        csw_req;
  logic [3:0]  csw_core;
  logic        csw_done;
  logic        csw_ok;
  logic        cfg_req;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        cfg_ack;
  logic [7:0]  cfg_rdata;
  logic        win_req;
  logic        win_we;
  logic [15:0] win_addr;
  logic [1:0]  win_be;
  logic [15:0] win_wdata;
  logic        win_ack;
  logic [15:0] win_rdata;

  // environment knobs, driven only by the stimulus process
  logic        csw_fail = 1'b0;
  logic        seg_stuck = 1'b0;
  int          flaky_until = 0;

  // models, driven only by their own processes
  logic        hw_seg;
  logic [15:0] mem [0:63];
  int          cfg_wr_cnt;
  int          csw_cnt;
  int          win_cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_window_xlat u_seg_window_xlat (.*);

  // core switch sequencer model
  assign csw_ok = !csw_fail;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csw_done <= 1'b0;
      csw_cnt  <= 0;
    end else begin
      csw_done <= csw_req && !csw_done;
      if (csw_req && csw_done) csw_cnt <= csw_cnt + 1;
    end
  end

  // segment register model
  assign cfg_rdata = {7'h0, hw_seg};
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ack    <= 1'b0;
      hw_seg     <= 1'b1;
      cfg_wr_cnt <= 0;
    end else begin
      cfg_ack <= cfg_req && !cfg_ack;
      if (cfg_req && cfg_ack && cfg_we) begin
        cfg_wr_cnt <= cfg_wr_cnt + 1;
        if (!seg_stuck && cfg_wr_cnt >= flaky_until) hw_seg <= cfg_wdata[0];
      end
    end
  end

  // two-segment window model, 32 words per segment
  assign win_rdata = mem[{hw_seg, win_addr[5:1]}];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_ack <= 1'b0;
      win_cnt <= 0;
      for (int i = 0; i < 64; i++) mem[i] <= 16'h0;
    end else begin
      win_ack <= win_req && !win_ack;
      if (win_req && win_ack) begin
        win_cnt <= win_cnt + 1;
        if (win_we) begin
          if (win_be[0]) mem[{hw_seg, win_addr[5:1]}][7:0]  <= win_wdata[7:0];
          if (win_be[1]) mem[{hw_seg, win_addr[5:1]}][15:8] <= win_wdata[15:8];
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] sz, input logic we, input logic [3:0] core,
                        input logic [15:0] off, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid  = 1'b1;
    req_size   = sz;
    req_write  = we;
    req_core   = core;
    req_offset = off;
    req_wdata  = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    er = rsp_err;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  sz;
    logic        we;
    logic [3:0]  core;
    logic [15:0] off;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [1:0]  dcsw;
    logic [1:0]  dseg;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 1'b1, 4'd2, 16'h0010, 32'hA1B2C3D4, 32'h0,        2'd1, 2'd0},
    '{2'd2, 1'b0, 4'd2, 16'h0010, 32'h0,        32'hA1B2C3D4, 2'd0, 2'd0},
    '{2'd1, 1'b0, 4'd2, 16'h0012, 32'h0,        32'h0000A1B2, 2'd0, 2'd0},
    '{2'd0, 1'b0, 4'd2, 16'h0013, 32'h0,        32'h000000A1, 2'd0, 2'd0},
    '{2'd0, 1'b0, 4'd2, 16'h0010, 32'h0,        32'h000000D4, 2'd0, 2'd0},
    '{2'd1, 1'b1, 4'd2, 16'h0814, 32'h5566,     32'h0,        2'd0, 2'd1},
    '{2'd1, 1'b0, 4'd2, 16'h0014, 32'h0,        32'h0,        2'd0, 2'd1},
    '{2'd1, 1'b0, 4'd2, 16'h0814, 32'h0,        32'h00005566, 2'd0, 2'd1},
    '{2'd0, 1'b1, 4'd5, 16'h0815, 32'h77,       32'h0,        2'd1, 2'd0},
    '{2'd1, 1'b0, 4'd5, 16'h0814, 32'h0,        32'h00007766, 2'd0, 2'd0},
    '{2'd2, 1'b0, 4'd3, 16'h0012, 32'h0,        32'h0000A1B2, 2'd1, 2'd1},
    '{2'd2, 1'b1, 4'd3, 16'h0FFC, 32'h01234567, 32'h0,        2'd0, 2'd1},
    '{2'd2, 1'b0, 4'd3, 16'h0FFC, 32'h0,        32'h01234567, 2'd0, 2'd0},
    '{2'd0, 1'b0, 4'd3, 16'h0FFF, 32'h0,        32'h00000001, 2'd0, 2'd0},
    '{2'd1, 1'b0, 4'd3, 16'h07FE, 32'h0,        32'h0,        2'd0, 2'd1}
  };

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin : stim
    logic [31:0] rd;
    logic        er;
    int          c0, s0, w0;

    // R8: reset state and initial segment sync
    repeat (3) @(negedge clk);
    check("R8 req_ready in reset", {31'h0, req_ready}, 32'h0);
    check("R8 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    check("R10 port requests in reset", {29'h0, csw_req, cfg_req, win_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 req_ready held during init", {31'h0, req_ready}, 32'h0);
    while (!req_ready) @(negedge clk);
    check("R8 init writes", cfg_wr_cnt, 1);
    check("R8 init segment", {31'h0, hw_seg}, 32'h0);

    // R1/R2/R3/R5/R6/R10: vector table
    for (int i = 0; i < NV; i++) begin
      c0 = csw_cnt;
      s0 = cfg_wr_cnt;
      do_req(VECS[i].sz, VECS[i].we, VECS[i].core, VECS[i].off, VECS[i].wd, rd, er);
      if (!VECS[i].we) check($sformatf("R1/R5/R6/R10 data vec %0d", i), rd, VECS[i].exp);
      check($sformatf("R7 err vec %0d", i), {31'h0, er}, 32'h0);
      check($sformatf("R2 core changes vec %0d", i), csw_cnt - c0, {30'h0, VECS[i].dcsw});
      check($sformatf("R3 seg writes vec %0d", i), cfg_wr_cnt - s0, {30'h0, VECS[i].dseg});
    end

    // R4: two mismatched rounds, success in the last allowed round
    flaky_until = cfg_wr_cnt + 2;
    s0 = cfg_wr_cnt;
    do_req(2'd1, 1'b0, 4'd3, 16'h0800, 32'h0, rd, er);
    check("R4 retried rounds", cfg_wr_cnt - s0, MAX_TRIES);
    check("R4 err after late match", {31'h0, er}, 32'h0);
    check("R4 data after retry", rd, 32'h0);

    // R7: segment change fails; write dropped, read gives ones
    seg_stuck = 1'b1;
    s0 = cfg_wr_cnt;
    w0 = win_cnt;
    do_req(2'd1, 1'b1, 4'd3, 16'h0016, 32'hBEEF, rd, er);
    check("R7 write err", {31'h0, er}, 32'h1);
    check("R4 rounds on failure", cfg_wr_cnt - s0, MAX_TRIES);
    check("R7 no window beat", win_cnt - w0, 0);
    do_req(2'd1, 1'b0, 4'd3, 16'h0016, 32'h0, rd, er);
    check("R7 read ones 16", rd, 32'h0000FFFF);
    check("R7 read err", {31'h0, er}, 32'h1);
    seg_stuck = 1'b0;
    s0 = cfg_wr_cnt;
    do_req(2'd1, 1'b0, 4'd3, 16'h0816, 32'h0, rd, er);
    check("R7 segment cache invalidated", cfg_wr_cnt - s0, 1);
    check("R7 dropped write left window", rd, 32'h0);

    // R7: core change fails
    csw_fail = 1'b1;
    c0 = csw_cnt;
    s0 = cfg_wr_cnt;
    w0 = win_cnt;
    do_req(2'd2, 1'b0, 4'd7, 16'h0010, 32'h0, rd, er);
    check("R7 read ones 32", rd, 32'hFFFFFFFF);
    check("R7 core err", {31'h0, er}, 32'h1);
    check("R7 no seg change after core fail", cfg_wr_cnt - s0, 0);
    check("R7 no beat after core fail", win_cnt - w0, 0);
    do_req(2'd0, 1'b0, 4'd7, 16'h0011, 32'h0, rd, er);
    check("R7 read ones 8", rd, 32'h000000FF);
    csw_fail = 1'b0;
    c0 = csw_cnt;
    do_req(2'd1, 1'b0, 4'd3, 16'h0010, 32'h0, rd, er);
    check("R7 core cache invalidated", csw_cnt - c0, 1);
    check("R10 data after both changes", rd, 32'h0000C3D4);

    // R9: response back-pressure
    rsp_ready = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_size = 2'd1; req_write = 1'b0; req_core = 4'd3; req_offset = 16'h0012;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R9 rsp held", {31'h0, rsp_valid}, 32'h1);
    check("R9 no new accept", {31'h0, req_ready}, 32'h0);
    check("R9 held data", rsp_rdata, 32'h0000A1B2);
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 ready after handshake", {31'h0, req_ready}, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule